// File: doc/BRIEF.md
# Little-Endian Load Data Aligner

This block sits at the writeback end of the load path in a 32-bit little-endian processor. It is given the naturally aligned word that memory returned, the two low bits of the load address, a code for the kind of load, and the present contents of the destination register. From these it forms the value that goes back into the register file.

Byte and halfword loads select a lane of the word and then sign-extend or zero-extend it. Full-word loads pass the word through unchanged. The two partial unaligned loads (merge-high and merge-low) each place part of the memory word into the register and keep the rest of the old register value. The result is captured in an output register whose valid flag trails the input valid by one clock. Memory access, alignment faults and register file control are handled elsewhere.

Top module: `load_aligner`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid and out_data are both cleared to zero on that edge.
- R2: Load code 0 (signed byte) selects byte lane k = addr_lo, held in bits 8k+7..8k of mem_word. It returns that byte sign-extended. For mem_word 0x76543210 the offsets 0..3 give 0x10, 0x32, 0x54 and 0x76, and a byte of 0x80 gives 0xFFFFFF80.
- R3: Load code 4 (unsigned byte) returns the same lane zero-extended, so 0x80 gives 0x00000080 and 0xFF gives 0x000000FF.
- R4: Load code 1 (signed halfword) takes bits 15..0 when addr_lo[1]=0 and bits 31..16 when addr_lo[1]=1, ignores addr_lo[0], and sign-extends, so 0x8000 gives 0xFFFF8000.
- R5: Load code 5 (unsigned halfword) selects the half the same way and zero-extends it, so 0xFFFF gives 0x0000FFFF.
- R6: Load code 2 (word) returns mem_word unchanged, for example 0x08000000.
- R7: Load code 3 (merge-high) at offset k writes memory bytes 0..k into register bytes 3-k..3 and keeps the lower register bytes. With memory 0x03020100 and an old value of 5, offsets 0..3 give 0x00000005, 0x01000005, 0x02010005 and 0x03020100.
- R8: Load code 6 (merge-low) at offset k writes memory bytes k..3 into register bytes 0..3-k and keeps the upper register bytes. With memory 0x03020100, offset 0 gives 0x03020100 whatever the old value is. With an old value of 0x50000000, offsets 1 and 2 give 0x50030201 and 0x50000302.
- R9: Load code 7 (unused) returns zero.
- R10: A load presented with in_valid high appears on out_data one rising edge later, with out_valid high. When in_valid is low at an edge, out_valid drops and out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A load result is presented this cycle |
| load_kind | input | 3 | Load type code (see R2 to R9) |
| addr_lo | input | 2 | Low address bits, the byte offset |
| mem_word | input | 32 | Aligned word read from memory |
| old_reg | input | 32 | Current destination register value |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 32 | Value to write back |

## Verification
The only state in the block is the output register and its valid flag, so any fault shows at the ports one edge after the load that caused it. A wrong lane choice or a wrong extension corrupts whole bytes of out_data in that same cycle. A wrong capture enable shows either as out_data changing while in_valid is low, or as out_valid that does not match in_valid from the previous cycle. A mistake at the merge boundary only shows when the old register bytes differ from the memory bytes, so the merge tests use old values that can be told apart from memory.

// File: rtl/ldal_pkg.sv
// Shared definitions for the load data aligner.
// Assumes the load-type code is three bits wide and that code 7 is unused.
package ldal_pkg;

    typedef enum logic [2:0] {
        LK_BYTE_S = 3'd0,
        LK_HALF_S = 3'd1,
        LK_WORD   = 3'd2,
        LK_MERGE_HI = 3'd3,
        LK_BYTE_U = 3'd4,
        LK_HALF_U = 3'd5,
        LK_MERGE_LO = 3'd6,
        LK_UNUSED = 3'd7
    } ld_kind_e;

endpackage

// File: rtl/ldal_extract.sv
// Picks a byte or halfword lane out of a little-endian memory word and
// widens it to the full data width, either sign-extended or zero-extended.
// Assumes DATA_W is a power of two of at least 32. For halfwords the lowest
// offset bit is ignored; alignment is checked elsewhere.
module ldal_extract #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] mem_word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              is_half,
    input  logic              sext,
    output logic [DATA_W-1:0] lane_out
);

    logic [OFS_W-1:0]  sel_ofs;
    logic [DATA_W-1:0] shifted;
    logic [7:0]        b_lane;
    logic [15:0]       h_lane;

    // Lane select: clear bit 0 for halfwords, then shift the lane down.
    always_comb begin
        sel_ofs = is_half ? {ofs[OFS_W-1:1], 1'b0} : ofs;
        shifted = mem_word >> {sel_ofs, 3'b000};
        b_lane  = shifted[7:0];
        h_lane  = shifted[15:0];
    end

    // Widening: replicate the lane's top bit or fill with zeros.
    always_comb begin
        if (is_half)
            lane_out = {{(DATA_W-16){sext & h_lane[15]}}, h_lane};
        else
            lane_out = {{(DATA_W-8){sext & b_lane[7]}}, b_lane};
    end

endmodule

// File: rtl/ldal_merge.sv
// Forms the partial unaligned word loads on a little-endian word. Merge-high
// moves the low memory bytes into the top register bytes. Merge-low moves the
// high memory bytes into the bottom register bytes. In both cases the register
// bytes that are not written keep their old value.
// Assumes mem_word is the aligned word holding the addressed byte.
module ldal_merge #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] old_reg,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              use_high,
    output logic [DATA_W-1:0] merged
);

    localparam logic [OFS_W-1:0] TOP_LANE = OFS_W'(NBYTES - 1);

    logic [OFS_W-1:0]  pivot;
    logic [DATA_W-1:0] hi_shift;
    logic [DATA_W-1:0] lo_shift;

    // Pivot lane and the two shifted copies of the memory word.
    always_comb begin
        pivot    = TOP_LANE - ofs;
        hi_shift = mem_word << {pivot, 3'b000};
        lo_shift = mem_word >> {ofs, 3'b000};
    end

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        logic take_mem;
        // Per-lane choice between a memory byte and the old register byte.
        always_comb begin
            take_mem = use_high ? (OFS_W'(j) >= pivot) : (OFS_W'(j) <= pivot);
            if (!take_mem)
                merged[8*j +: 8] = old_reg[8*j +: 8];
            else if (use_high)
                merged[8*j +: 8] = hi_shift[8*j +: 8];
            else
                merged[8*j +: 8] = lo_shift[8*j +: 8];
        end
    end

endmodule

// File: rtl/load_aligner.sv
// Load writeback aligner: decodes the load code, takes the result from the
// lane extractor, the merge unit or the raw word, and registers it together
// with a valid flag. Assumes a synchronous active-low reset, and that the
// output register loads only when in_valid is high.
module load_aligner #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        load_kind,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] old_reg,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import ldal_pkg::*;

    ld_kind_e          kind;
    logic              is_half;
    logic              sext;
    logic              use_high;
    logic [DATA_W-1:0] lane_val;
    logic [DATA_W-1:0] merge_val;
    logic [DATA_W-1:0] next_data;

    // Decode of the load code into control for the two datapath units.
    always_comb begin
        kind     = ld_kind_e'(load_kind);
        is_half  = (kind == LK_HALF_S) || (kind == LK_HALF_U);
        sext     = (kind == LK_BYTE_S) || (kind == LK_HALF_S);
        use_high = (kind == LK_MERGE_HI);
    end

    ldal_extract #(.DATA_W(DATA_W)) u_extract (
        .mem_word (mem_word),
        .ofs      (addr_lo),
        .is_half  (is_half),
        .sext     (sext),
        .lane_out (lane_val)
    );

    ldal_merge #(.DATA_W(DATA_W)) u_merge (
        .mem_word (mem_word),
        .old_reg  (old_reg),
        .ofs      (addr_lo),
        .use_high (use_high),
        .merged   (merge_val)
    );

    // Result select by load code; the unused code yields zero.
    always_comb begin
        unique case (kind)
            LK_BYTE_S, LK_BYTE_U,
            LK_HALF_S, LK_HALF_U:     next_data = lane_val;
            LK_WORD:                  next_data = mem_word;
            LK_MERGE_HI, LK_MERGE_LO: next_data = merge_val;
            default:                  next_data = '0;
        endcase
    end

    // Output stage: capture on in_valid, valid trails in_valid by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= next_data;
        end
    end

endmodule

// File: rtl/ldal_checker.sv
// Property checks for load_aligner, attached to it by bind. Each property
// relates the registered outputs to the inputs one clock earlier.
module ldal_checker #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        load_kind,
    input logic [OFS_W-1:0]  addr_lo,
    input logic [DATA_W-1:0] mem_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    // R10: valid trails the input valid.
    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: the data is held while nothing is presented.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R2: a signed byte fills the upper bits with its own top bit.
    a_r2_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd0) |=> out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}});
    // R3: an unsigned byte has zero upper bits.
    a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd4) |=> out_data[DATA_W-1:8] == '0);
    // R5: an unsigned halfword has zero upper bits.
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd5) |=> out_data[DATA_W-1:16] == '0);
    // R6: a word load passes the memory word through.
    a_r6_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd2) |=> out_data == $past(mem_word));
    // R8: merge-low at offset zero replaces the whole register.
    a_r8_low_full: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd6 && addr_lo == '0) |=> out_data == $past(mem_word));
    // R9: the unused code returns zero.
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && load_kind == 3'd7) |=> out_data == '0);

endmodule

bind load_aligner ldal_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .load_kind (load_kind),
    .addr_lo   (addr_lo),
    .mem_word  (mem_word),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_load_aligner.sv
// Directed bench for load_aligner: one task per scenario, each checking its results.
module sim_load_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  load_kind = 3'd0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] mem_word = 32'h0;
    logic [31:0] old_reg = 32'h0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    load_aligner u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .load_kind(load_kind),
        .addr_lo(addr_lo), .mem_word(mem_word), .old_reg(old_reg),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Presents one load for one edge and checks the registered result.
    task automatic load(input string req, input logic [2:0] k, input logic [1:0] ofs,
                        input logic [31:0] mem, input logic [31:0] old,
                        input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; load_kind = k; addr_lo = ofs; mem_word = mem; old_reg = old;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_data, exp);
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        in_valid = 1'b1; load_kind = 3'd2; mem_word = 32'hDEADBEEF;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 data", out_data, 32'h0);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_byte_signed();
        load("R2 ofs0", 3'd0, 2'd0, 32'h76543210, 32'h0, 32'h00000010);
        load("R2 ofs1", 3'd0, 2'd1, 32'h76543210, 32'h0, 32'h00000032);
        load("R2 ofs2", 3'd0, 2'd2, 32'h76543210, 32'h0, 32'h00000054);
        load("R2 ofs3", 3'd0, 2'd3, 32'h76543210, 32'h0, 32'h00000076);
        load("R2 0x80", 3'd0, 2'd3, 32'h8000FF01, 32'h0, 32'hFFFFFF80);
        load("R2 0xFF", 3'd0, 2'd1, 32'h8000FF01, 32'h0, 32'hFFFFFFFF);
        load("R2 hi neg", 3'd0, 2'd3, 32'hFEDCBA98, 32'h0, 32'hFFFFFFFE);
    endtask

    task automatic t_byte_unsigned();
        load("R3 0x80", 3'd4, 2'd3, 32'h8000FF01, 32'h0, 32'h00000080);
        load("R3 0xFF", 3'd4, 2'd1, 32'h8000FF01, 32'h0, 32'h000000FF);
        load("R3 ofs0", 3'd4, 2'd0, 32'hFEDCBA98, 32'h0, 32'h00000098);
    endtask

    task automatic t_half();
        load("R4 low", 3'd1, 2'd0, 32'h8000FFFF, 32'h0, 32'hFFFFFFFF);
        load("R4 high", 3'd1, 2'd2, 32'h8000FFFF, 32'h0, 32'hFFFF8000);
        load("R4 bit0 ignored", 3'd1, 2'd3, 32'h80000001, 32'h0, 32'hFFFF8000);
        load("R4 positive", 3'd1, 2'd1, 32'h80000001, 32'h0, 32'h00000001);
        load("R5 0x8000", 3'd5, 2'd2, 32'h8000FFFF, 32'h0, 32'h00008000);
        load("R5 0xFFFF", 3'd5, 2'd1, 32'h8000FFFF, 32'h0, 32'h0000FFFF);
    endtask

    task automatic t_word();
        load("R6 word", 3'd2, 2'd0, 32'h08000000, 32'h12345678, 32'h08000000);
        load("R6 word neg", 3'd2, 2'd0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
    endtask

    task automatic t_merge_high();
        load("R7 ofs0 old0", 3'd3, 2'd0, 32'h03020100, 32'h0, 32'h00000000);
        load("R7 ofs0", 3'd3, 2'd0, 32'h03020100, 32'h5, 32'h00000005);
        load("R7 ofs1", 3'd3, 2'd1, 32'h03020100, 32'h5, 32'h01000005);
        load("R7 ofs2", 3'd3, 2'd2, 32'h03020100, 32'h5, 32'h02010005);
        load("R7 ofs3", 3'd3, 2'd3, 32'h03020100, 32'h5, 32'h03020100);
        load("R7 keep", 3'd3, 2'd1, 32'h03020100, 32'hAABBCCDD, 32'h0100CCDD);
    endtask

    task automatic t_merge_low();
        load("R8 ofs0", 3'd6, 2'd0, 32'h03020100, 32'h00000500, 32'h03020100);
        load("R8 ofs1", 3'd6, 2'd1, 32'h03020100, 32'h50000000, 32'h50030201);
        load("R8 ofs2", 3'd6, 2'd2, 32'h03020100, 32'h50000000, 32'h50000302);
        load("R8 ofs3", 3'd6, 2'd3, 32'h03020100, 32'h50000000, 32'h50000003);
        load("R8 keep", 3'd6, 2'd2, 32'h03020100, 32'hAABBCCDD, 32'hAABB0302);
    endtask

    task automatic t_unused();
        load("R9 unused", 3'd7, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000);
    endtask

    // R10: no capture while in_valid is low, then a single-edge result.
    task automatic t_hold();
        load("R10 setup", 3'd2, 2'd0, 32'hCAFEF00D, 32'h0, 32'hCAFEF00D);
        @(negedge clk);
        load_kind = 3'd2; mem_word = 32'h11111111;
        @(negedge clk);
        check("R10 hold data", out_data, 32'hCAFEF00D);
        check("R10 valid low", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R10 still held", out_data, 32'hCAFEF00D);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_byte_signed();
        t_byte_unsigned();
        t_half();
        t_word();
        t_merge_high();
        t_merge_low();
        t_unused();
        t_hold();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule